// File: doc/BRIEF.md
# DMA Bus Ownership Handshake Controller

This controller sits on the processor side of a shared bus and decides, cycle by cycle, whether the processor or a single external DMA master owns that bus. The processor reports its own bus activity with a cycle-active level and a cycle-done strobe. The DMA master uses a four-phase exchange: it raises a request, waits for the grant, confirms with a grant-acknowledge, and later hands the bus back with a release. The controller answers each release with a one-cycle acknowledge. The processor's stalled cycle then starts exactly where it was held.

Ownership changes only at a boundary between processor bus cycles. Such a boundary can fall between two cycles of the same instruction. Two conditions keep the bus with the processor. The first is a lock level, driven by lock and unlock instructions. The second is an open read-modify-write group, a run of `RMW_LEN` processor cycles that must not be split. A request that is blocked stays pending and wins at the first boundary where neither condition holds. While the DMA master owns the bus, a snoop-enable output tells the cache to watch the addresses on the bus.

Top module: `busown_arbiter`

## Requirements
- R1: Reset is synchronous and active-high. At the first clock after reset, bus_grant, snoop_en and rel_ack are low, and cpu_stall is low while cpu_cyc_active is low.
- R2: bus_grant never rises while a processor bus cycle is in progress. A cycle is in progress from the edge that accepts cpu_cyc_active until the edge that samples cpu_cyc_done. With dma_req high and grants allowed, bus_grant goes high after the first edge following that boundary.
- R3: After the grant, snoop_en stays low until dma_gack is sampled high with dma_req still high. snoop_en is high from the next edge for as long as the DMA master owns the bus, and bus_grant stays high throughout.
- R4: When dma_rel is sampled during DMA ownership, the next cycle has rel_ack high and bus_grant and snoop_en low. rel_ack lasts exactly one cycle, after which the controller is idle.
- R5: If dma_req is sampled low while the grant is waiting for its acknowledge, bus_grant is low after that edge and the controller is idle.
- R6: A processor cycle that ends with rmw_flag high (sampled with cpu_cyc_done) opens a group of RMW_LEN cycles (default 2). No grant is issued until the cpu_cyc_done of the last cycle of the group.
- R7: While lock_hold is high, no new grant is issued. When lock_hold goes low, grants are allowed again.
- R8: A request blocked by R6 or R7 stays pending. bus_grant rises after the first edge at which the controller is idle and the block has cleared.
- R9: cpu_stall is high whenever cpu_cyc_active is high and the processor cannot start its cycle in that clock: the grant is pending acknowledge, the DMA master owns the bus, a release is being acknowledged, or the DMA master is taking the bus in that same cycle.
- R10: At an idle boundary, an allowed DMA request wins over a processor cycle start in the same clock. Once the release completes, the held processor cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_req | input | 1 | DMA master asks for the bus |
| dma_gack | input | 1 | DMA master confirms it has taken the grant |
| dma_rel | input | 1 | DMA master hands the bus back |
| cpu_cyc_active | input | 1 | Processor wants or runs a bus cycle |
| cpu_cyc_done | input | 1 | Strobe marking the last clock of a processor bus cycle |
| lock_hold | input | 1 | Lock level set by lock/unlock instructions; blocks new grants |
| rmw_flag | input | 1 | The finishing processor cycle is the read of a read-modify-write group |
| bus_grant | output | 1 | Bus granted to the DMA master |
| cpu_stall | output | 1 | Processor must hold its pending cycle |
| snoop_en | output | 1 | Cache watches bus addresses (DMA owns the bus) |
| rel_ack | output | 1 | One-cycle acknowledge of a release |

## Verification
A wrong ownership state shows at the ports within one clock. If the controller sits in the wrong phase, bus_grant, snoop_en or rel_ack differ from the expected handshake phase right after the edge that moved it. A stuck or miscounted read-modify-write group shows up only at the next boundary: a grant appears one clock early, or is missing one clock after the group's last done strobe. A lost pending request shows as bus_grant staying low after the block clears. cpu_stall is combinational, so a wrong priority decision shows in the same clock as the conflicting request and cycle start.

// File: rtl/busown_pkg.sv
package busown_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_CPU    = 3'd1,
    ST_GWAIT  = 3'd2,
    ST_DMA    = 3'd3,
    ST_RELACK = 3'd4
  } own_state_t;

  // A new grant is allowed only when neither the lock nor an rmw group blocks it
  function automatic logic grant_allowed(input logic lock_lvl, input logic rmw_open_lvl);
    return !(lock_lvl || rmw_open_lvl);
  endfunction

  // States in which the DMA side holds or is about to hold the bus
  function automatic logic dma_side(input own_state_t st);
    return (st == ST_GWAIT) || (st == ST_DMA) || (st == ST_RELACK);
  endfunction

  // States in which bus_grant is driven
  function automatic logic grant_level(input own_state_t st);
    return (st == ST_GWAIT) || (st == ST_DMA);
  endfunction

endpackage

// File: rtl/busown_rmw_track.sv
module busown_rmw_track #(
  parameter int RMW_LEN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cyc_end,
  input  logic rmw_flag,
  output logic rmw_open
);

  localparam int CW = $clog2(RMW_LEN + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(RMW_LEN - 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
    end else if (cyc_end) begin
      if (left_q != '0) begin
        left_q <= left_q - 1'b1;
      end else if (rmw_flag) begin
        left_q <= LOAD_VAL;
      end
    end
  end

  assign rmw_open = (left_q != '0);

endmodule

// File: rtl/busown_gate.sv
module busown_gate
  import busown_pkg::*;
(
  input  own_state_t state,
  input  logic       dma_req,
  input  logic       lock_hold,
  input  logic       rmw_open,
  input  logic       cpu_cyc_active,
  output logic       take,
  output logic       cpu_stall
);

  logic eligible;

  always_comb begin
    eligible  = grant_allowed(lock_hold, rmw_open);
    take      = (state == ST_IDLE) && dma_req && eligible;
    cpu_stall = cpu_cyc_active && (dma_side(state) || take);
  end

endmodule

// File: rtl/busown_fsm.sv
module busown_fsm
  import busown_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       take,
  input  logic       cpu_cyc_active,
  input  logic       cpu_cyc_done,
  input  logic       dma_req,
  input  logic       dma_gack,
  input  logic       dma_rel,
  output own_state_t state,
  output logic       cyc_end
);

  own_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: begin
        if (take)                nxt = ST_GWAIT;
        else if (cpu_cyc_active) nxt = ST_CPU;
      end
      ST_CPU: begin
        if (cpu_cyc_done)        nxt = ST_IDLE;
      end
      ST_GWAIT: begin
        if (!dma_req)            nxt = ST_IDLE;
        else if (dma_gack)       nxt = ST_DMA;
      end
      ST_DMA: begin
        if (dma_rel)             nxt = ST_RELACK;
      end
      ST_RELACK:                 nxt = ST_IDLE;
      default:                   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  assign cyc_end = (state == ST_CPU) && cpu_cyc_done;

endmodule

// File: rtl/busown_arbiter.sv
module busown_arbiter
  import busown_pkg::*;
#(
  parameter int RMW_LEN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic dma_req,
  input  logic dma_gack,
  input  logic dma_rel,
  input  logic cpu_cyc_active,
  input  logic cpu_cyc_done,
  input  logic lock_hold,
  input  logic rmw_flag,
  output logic bus_grant,
  output logic cpu_stall,
  output logic snoop_en,
  output logic rel_ack
);

  own_state_t state;
  logic       take;
  logic       cyc_end;
  logic       rmw_open;
  logic       cyc_busy;

  busown_fsm u_fsm (
    .clk            (clk),
    .rst            (rst),
    .take           (take),
    .cpu_cyc_active (cpu_cyc_active),
    .cpu_cyc_done   (cpu_cyc_done),
    .dma_req        (dma_req),
    .dma_gack       (dma_gack),
    .dma_rel        (dma_rel),
    .state          (state),
    .cyc_end        (cyc_end)
  );

  busown_rmw_track #(.RMW_LEN(RMW_LEN)) u_rmw (
    .clk      (clk),
    .rst      (rst),
    .cyc_end  (cyc_end),
    .rmw_flag (rmw_flag),
    .rmw_open (rmw_open)
  );

  busown_gate u_gate (
    .state          (state),
    .dma_req        (dma_req),
    .lock_hold      (lock_hold),
    .rmw_open       (rmw_open),
    .cpu_cyc_active (cpu_cyc_active),
    .take           (take),
    .cpu_stall      (cpu_stall)
  );

  assign bus_grant = grant_level(state);
  assign snoop_en  = (state == ST_DMA);
  assign rel_ack   = (state == ST_RELACK);
  assign cyc_busy  = (state == ST_CPU);

endmodule

// File: rtl/busown_arbiter_chk.sv
module busown_arbiter_chk (
  input logic clk,
  input logic rst,
  input logic dma_req,
  input logic dma_gack,
  input logic dma_rel,
  input logic cpu_cyc_active,
  input logic lock_hold,
  input logic bus_grant,
  input logic cpu_stall,
  input logic snoop_en,
  input logic rel_ack,
  input logic rmw_open,
  input logic cyc_busy
);

  assert_grant_boundary_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_grant) |-> $past(!cyc_busy && dma_req));

  assert_snoop_after_ack_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(snoop_en) |-> $past(bus_grant && dma_gack && dma_req));

  assert_snoop_has_grant_R3: assert property (@(posedge clk) disable iff (rst)
    snoop_en |-> bus_grant);

  assert_relack_source_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(rel_ack) |-> $past(snoop_en && dma_rel));

  assert_relack_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    rel_ack |=> !rel_ack);

  assert_withdraw_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_grant && !snoop_en && !dma_req) |=> !bus_grant);

  assert_rmw_block_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_grant) |-> $past(!rmw_open));

  assert_lock_block_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_grant) |-> $past(!lock_hold));

  assert_stall_on_grant_R9: assert property (@(posedge clk) disable iff (rst)
    (cpu_cyc_active && (bus_grant || rel_ack)) |-> cpu_stall);

endmodule

bind busown_arbiter busown_arbiter_chk u_chk (.*);

// File: tb/busown_arbiter_tb.sv
module busown_arbiter_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dma_req = 0, dma_gack = 0, dma_rel = 0;
  logic cpu_cyc_active = 0, cpu_cyc_done = 0, lock_hold = 0, rmw_flag = 0;
  logic bus_grant, cpu_stall, snoop_en, rel_ack;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  busown_arbiter #(.RMW_LEN(2)) u_dut (
    .clk(clk), .rst(rst), .dma_req(dma_req), .dma_gack(dma_gack), .dma_rel(dma_rel),
    .cpu_cyc_active(cpu_cyc_active), .cpu_cyc_done(cpu_cyc_done),
    .lock_hold(lock_hold), .rmw_flag(rmw_flag),
    .bus_grant(bus_grant), .cpu_stall(cpu_stall), .snoop_en(snoop_en), .rel_ack(rel_ack)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; dma_req = 0; dma_gack = 0; dma_rel = 0;
    cpu_cyc_active = 0; cpu_cyc_done = 0; lock_hold = 0; rmw_flag = 0;
    nxt(); nxt();
    rst = 0;
  endtask

  // Ack, own, release, back to idle with full handshake checks
  task automatic finish_dma(input string tag);
    dma_gack = 1;
    nxt();
    chk("R3", {tag, " snoop after ack"}, snoop_en, 1'b1);
    chk("R3", {tag, " grant while owned"}, bus_grant, 1'b1);
    dma_gack = 0; dma_rel = 1;
    nxt();
    chk("R4", {tag, " rel_ack"}, rel_ack, 1'b1);
    chk("R4", {tag, " grant low in relack"}, bus_grant, 1'b0);
    chk("R4", {tag, " snoop low in relack"}, snoop_en, 1'b0);
    dma_rel = 0; dma_req = 0;
    nxt();
    chk("R4", {tag, " rel_ack one cycle"}, rel_ack, 1'b0);
  endtask

  initial begin
    do_reset();
    chk("R1", "grant after reset", bus_grant, 1'b0);
    chk("R1", "snoop after reset", snoop_en, 1'b0);
    chk("R1", "rel_ack after reset", rel_ack, 1'b0);
    chk("R1", "stall after reset", cpu_stall, 1'b0);

    // Sweep over lock and rmw combinations with a request raised mid-cycle
    for (int l = 0; l < 2; l++) begin
      for (int f = 0; f < 2; f++) begin
        string tag;
        tag = $sformatf("l%0d f%0d", l, f);
        do_reset();
        cpu_cyc_active = 1;
        nxt();                      // CPU cycle accepted
        dma_req = 1; lock_hold = logic'(l);
        nxt();
        chk("R2", {tag, " no grant mid-cycle"}, bus_grant, 1'b0);
        chk("R9", {tag, " running cycle not stalled"}, cpu_stall, 1'b0);
        cpu_cyc_done = 1; rmw_flag = logic'(f);
        nxt();                      // boundary reached, idle
        cpu_cyc_done = 0; rmw_flag = 0; cpu_cyc_active = 0;
        #1;
        chk("R2", {tag, " no grant at done edge"}, bus_grant, 1'b0);
        nxt();
        chk((l != 0) ? "R7" : ((f != 0) ? "R6" : "R2"), {tag, " grant after boundary"},
            bus_grant, logic'(l == 0 && f == 0));
        if (f != 0) begin
          cpu_cyc_active = 1;       // write half of the rmw group
          #1;
          chk("R6", {tag, " cpu not stalled in rmw group"}, cpu_stall, 1'b0);
          nxt();
          cpu_cyc_done = 1; cpu_cyc_active = 0;
          nxt();
          cpu_cyc_done = 0;
          #1;
          chk("R6", {tag, " no grant at group end edge"}, bus_grant, 1'b0);
          nxt();
          chk((l != 0) ? "R7" : "R8", {tag, " grant after rmw group"}, bus_grant, logic'(l == 0));
        end
        if (l != 0) begin
          nxt();
          chk("R7", {tag, " still blocked by lock"}, bus_grant, 1'b0);
          lock_hold = 0;
          nxt();
          chk("R8", {tag, " pending granted after unlock"}, bus_grant, 1'b1);
        end
        finish_dma(tag);
      end
    end

    // Withdraw before acknowledge
    do_reset();
    dma_req = 1;
    nxt();
    chk("R2", "grant from idle", bus_grant, 1'b1);
    chk("R3", "no snoop before ack", snoop_en, 1'b0);
    dma_req = 0;
    nxt();
    chk("R5", "grant withdrawn", bus_grant, 1'b0);
    chk("R5", "no snoop after withdraw", snoop_en, 1'b0);
    cpu_cyc_active = 1;
    #1;
    chk("R5", "idle after withdraw, cpu free", cpu_stall, 1'b0);
    cpu_cyc_active = 0;

    // Same-clock conflict: DMA wins, CPU held, then resumes
    do_reset();
    dma_req = 1; cpu_cyc_active = 1;
    #1;
    chk("R10", "stall on same-clock take", cpu_stall, 1'b1);
    nxt();
    chk("R10", "dma wins boundary", bus_grant, 1'b1);
    chk("R9", "stall while grant waits", cpu_stall, 1'b1);
    dma_gack = 1;
    nxt();
    chk("R9", "stall while dma owns", cpu_stall, 1'b1);
    dma_gack = 0; dma_rel = 1;
    nxt();
    chk("R9", "stall during relack", cpu_stall, 1'b1);
    dma_rel = 0; dma_req = 0;
    nxt();
    chk("R10", "cpu free after release", cpu_stall, 1'b0);
    nxt();                          // CPU cycle accepted
    dma_req = 1;
    #1;
    chk("R10", "cpu cycle running after resume", cpu_stall, 1'b0);
    chk("R2", "no grant while resumed cycle runs", bus_grant, 1'b0);
    cpu_cyc_done = 1; cpu_cyc_active = 0;
    nxt();
    cpu_cyc_done = 0;
    nxt();
    chk("R2", "grant between cycles", bus_grant, 1'b1);

    // Reset during DMA ownership
    dma_gack = 1;
    nxt();
    dma_gack = 0;
    rst = 1;
    nxt();
    rst = 0; dma_req = 0;
    chk("R1", "reset clears ownership", snoop_en, 1'b0);
    chk("R1", "reset clears grant", bus_grant, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule